// File: doc/BRIEF.md
# Radio Register Init Sequencer

This block brings a 2.4 GHz transceiver into a known configuration after power-up and then confirms that the serial link to it is working. A single start pulse launches a fixed, ordered list of seven register writes through a register-access port (for example an SPI master that owns the chip-select and clock pins). After the last write it waits for a programmable settling interval. It then reads the address-width register and judges the link healthy from that register's bit pattern.

The access port sees one request at a time. The request, write flag, register address and write data stay stable until the port returns a one-cycle completion strobe, which carries read data on reads. When the probe read completes, the block raises a one-cycle done pulse and updates a sticky alive flag. Start pulses that arrive while a sequence is running are ignored.

Top module: `radio_init_seq`

## Requirements
- R1: The first access after a start pulse writes value 0x00 to register address 0x00, leaving the radio powered down.
- R2: The next writes go to address 0x01 with 0x03, address 0x02 with 0x03 and address 0x06 with 0x00, in that order.
- R3: They are followed by writes to address 0x07 with 0x70, address 0x1C with 0x03 and address 0x1D with 0x04, in that order, so the whole sequence is exactly seven writes.
- R4: While the request output is high and no completion strobe has arrived, the request, write flag, address and write data hold their values.
- R5: After the completion of the seventh write, the request stays low for exactly WAIT_CYCLES clock cycles before the probe request is issued.
- R6: The probe is a single read (write flag low) of register address 0x03.
- R7: alive is set after the probe when bits 7..2 of the read data are all zero and bits 1..0 are not both zero. Otherwise it is cleared.
- R8: alive is cleared on the clock edge that accepts a start pulse. It changes otherwise only on the edge that completes the probe, and it is high one cycle after that edge.
- R9: done pulses high for exactly one cycle, on the cycle after the probe completes, once per sequence.
- R10: A start pulse received while a sequence is in progress has no effect: no extra access is issued and done pulses only once.
- R11: After reset, request, done and alive are low, and no request is issued without a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches the sequence |
| acc_done_i | input | 1 | Completion strobe from the access port |
| acc_rdata_i | input | DATA_W | Read data, valid with the completion strobe |
| acc_req_o | output | 1 | Access request, held until completion |
| acc_write_o | output | 1 | 1 = register write, 0 = register read |
| acc_addr_o | output | ADDR_W | Register address of the access |
| acc_wdata_o | output | DATA_W | Write data of the access |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| alive_o | output | 1 | Link-health result of the last sequence |

## Verification
The hardest situation to reach from the ports is a second start pulse that lands in the middle of the write list. It has to leave the step index alone, and the settling counter must neither restart nor shorten. The bench answers from a responder with programmable latency. It watches its own access log and fires the extra start once the third write has completed. It then checks the full access count, the exact settling gap and the single done pulse. Alive results that change from one run to the next confirm that the flag is cleared at start and not only at the probe.

// File: rtl/radio_init_pkg.sv
package radio_init_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WRITE,
      ST_SETTLE,
      ST_PROBE
   } seq_state_t;

   localparam int unsigned NUM_STEPS  = 7;
   localparam int unsigned STEP_IDX_W = 3;
   localparam logic [4:0]  PROBE_REG  = 5'h03;

   typedef struct packed {
      logic [4:0] reg_sel;
      logic [7:0] value;
   } cfg_step_t;

   function automatic cfg_step_t step_at(input logic [STEP_IDX_W-1:0] i);
      cfg_step_t s;
      case (i)
         3'd0:    s = '{reg_sel: 5'h00, value: 8'h00};
         3'd1:    s = '{reg_sel: 5'h01, value: 8'h03};
         3'd2:    s = '{reg_sel: 5'h02, value: 8'h03};
         3'd3:    s = '{reg_sel: 5'h06, value: 8'h00};
         3'd4:    s = '{reg_sel: 5'h07, value: 8'h70};
         3'd5:    s = '{reg_sel: 5'h1C, value: 8'h03};
         default: s = '{reg_sel: 5'h1D, value: 8'h04};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/init_step_rom.sv
module init_step_rom
   import radio_init_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic [STEP_IDX_W-1:0] idx_i,
   output logic [ADDR_W-1:0]     addr_o,
   output logic [DATA_W-1:0]     data_o
);
   cfg_step_t step;
   assign step = step_at(idx_i);

   generate
      if (ADDR_W == 5) begin : g_addr_exact
         assign addr_o = step.reg_sel;
      end else begin : g_addr_pad
         assign addr_o = {{(ADDR_W-5){1'b0}}, step.reg_sel};
      end
      if (DATA_W == 8) begin : g_data_exact
         assign data_o = step.value;
      end else begin : g_data_pad
         assign data_o = {{(DATA_W-8){1'b0}}, step.value};
      end
   endgenerate
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int unsigned WAIT_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expired_o
);
   localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/width_probe_judge.sv
module width_probe_judge #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SIZE_BITS = 2
) (
   input  logic [DATA_W-1:0] rdata_i,
   output logic              healthy_o
);
   logic upper_clear, size_legal;
   assign upper_clear = (rdata_i[DATA_W-1:SIZE_BITS] == '0);
   assign size_legal  = (rdata_i[SIZE_BITS-1:0] != '0);
   assign healthy_o   = upper_clear && size_legal;
endmodule

// File: rtl/radio_init_seq.sv
module radio_init_seq
   import radio_init_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WAIT_CYCLES = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              acc_done_i,
   input  logic [DATA_W-1:0] acc_rdata_i,
   output logic              acc_req_o,
   output logic              acc_write_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [DATA_W-1:0] acc_wdata_o,
   output logic              done_o,
   output logic              alive_o
);
   localparam logic [STEP_IDX_W-1:0] LAST_IDX = STEP_IDX_W'(NUM_STEPS - 1);

   initial begin
      assert (ADDR_W >= 5)       else $error("ADDR_W must hold a 5-bit register address");
      assert (DATA_W >= 8)       else $error("DATA_W must hold a byte");
      assert (WAIT_CYCLES >= 1)  else $error("WAIT_CYCLES must be at least 1");
   end

   seq_state_t            state_q;
   logic [STEP_IDX_W-1:0] idx_q;
   logic [ADDR_W-1:0]     rom_addr;
   logic [DATA_W-1:0]     rom_data;
   logic                  settle_load, settle_expired, probe_ok;
   logic                  last_write_done, probe_done;

   init_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
      .idx_i  (idx_q),
      .addr_o (rom_addr),
      .data_o (rom_data)
   );

   assign last_write_done = (state_q == ST_WRITE) && acc_done_i && (idx_q == LAST_IDX);
   assign probe_done      = (state_q == ST_PROBE) && acc_done_i;
   assign settle_load     = last_write_done;

   settle_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (settle_load),
      .expired_o (settle_expired)
   );

   width_probe_judge #(.DATA_W(DATA_W), .SIZE_BITS(2)) u_judge (
      .rdata_i   (acc_rdata_i),
      .healthy_o (probe_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         done_o  <= 1'b0;
         alive_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WRITE;
                  idx_q   <= '0;
                  alive_o <= 1'b0;
               end
            end
            ST_WRITE: begin
               if (acc_done_i) begin
                  if (idx_q == LAST_IDX) state_q <= ST_SETTLE;
                  else                   idx_q   <= idx_q + 1'b1;
               end
            end
            ST_SETTLE: begin
               if (settle_expired) state_q <= ST_PROBE;
            end
            ST_PROBE: begin
               if (probe_done) begin
                  alive_o <= probe_ok;
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign acc_req_o   = (state_q == ST_WRITE) || (state_q == ST_PROBE);
   assign acc_write_o = (state_q == ST_WRITE);
   assign acc_addr_o  = (state_q == ST_PROBE) ? ADDR_W'(PROBE_REG) : rom_addr;
   assign acc_wdata_o = (state_q == ST_WRITE) ? rom_data : '0;
endmodule

// File: rtl/radio_init_chk.sv
module radio_init_chk #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              acc_done_i,
   input logic [DATA_W-1:0] acc_rdata_i,
   input logic              acc_req_o,
   input logic              acc_write_o,
   input logic [ADDR_W-1:0] acc_addr_o,
   input logic [DATA_W-1:0] acc_wdata_o,
   input logic              done_o,
   input logic              alive_o
);
   // R4: outstanding request holds its fields
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_o && !acc_done_i) |=> (acc_req_o && $stable(acc_write_o)
                                      && $stable(acc_addr_o) && $stable(acc_wdata_o)));

   // R1: register 0x00 is only ever written with 0x00
   p_power_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_o && acc_write_o && acc_addr_o == '0) |-> (acc_wdata_o == '0));

   // R6: every read targets the address-width register
   p_probe_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_o && !acc_write_o) |-> (acc_addr_o == ADDR_W'(3)));

   // R9: done lasts one cycle
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: done only follows a completed read
   p_done_after_probe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(acc_req_o && !acc_write_o && acc_done_i));

   // R8: alive only rises together with done
   p_alive_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alive_o) |-> done_o);
endmodule

bind radio_init_seq radio_init_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_radio_init_seq.sv
module sim_radio_init_seq;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned WAIT_C = 20;
   localparam int unsigned NVEC   = 7;
   // {probe value[7:0], latency[3:0], expected alive}
   localparam logic [12:0] VEC [NVEC] = '{
      {8'h03, 4'd0, 1'b1}, {8'h00, 4'd1, 1'b0}, {8'h01, 4'd2, 1'b1},
      {8'h04, 4'd0, 1'b0}, {8'h02, 4'd3, 1'b1}, {8'hFF, 4'd1, 1'b0},
      {8'h83, 4'd0, 1'b0}};
   localparam logic [4:0] EXP_A [7] = '{5'h00, 5'h01, 5'h02, 5'h06, 5'h07, 5'h1C, 5'h1D};
   localparam logic [7:0] EXP_D [7] = '{8'h00, 8'h03, 8'h03, 8'h00, 8'h70, 8'h03, 8'h04};

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, acc_done_i = 1'b0;
   logic [DATA_W-1:0] acc_rdata_i = '0;
   logic acc_req_o, acc_write_o, done_o, alive_o;
   logic [ADDR_W-1:0] acc_addr_o;
   logic [DATA_W-1:0] acc_wdata_o;

   int checks = 0, fails = 0, cyc = 0;
   int lat = 0, wcnt = 0, log_n = 0, gap = 0, done_cnt = 0, req_cnt = 0;
   logic [7:0] probe_val = 8'h00;
   logic        log_w [16];
   logic [4:0]  log_a [16];
   logic [7:0]  log_d [16];

   always #4 clk = ~clk;

   radio_init_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYCLES(WAIT_C)) u0 (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected <100000", cyc);
         finish_run();
      end
   end

   // access-port responder and monitors, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         acc_done_i = 1'b0;
         if (done_o) done_cnt++;
         if (acc_req_o) req_cnt++;
         if (log_n == 7 && !acc_req_o) gap++;
         if (rst_n && acc_req_o) begin
            if (wcnt >= lat) begin
               acc_done_i = 1'b1;
               acc_rdata_i = probe_val;
               if (log_n < 16) begin
                  log_w[log_n] = acc_write_o;
                  log_a[log_n] = acc_addr_o;
                  log_d[log_n] = acc_wdata_o;
               end
               log_n++;
               wcnt = 0;
            end else wcnt++;
         end
      end
   end

   task automatic run_seq(input logic [7:0] pv, input int l, input bit exp_alive,
                          input bit restart_mid);
      probe_val = pv; lat = l; wcnt = 0; log_n = 0; gap = 0; done_cnt = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(alive_o == 1'b0, "R8 alive cleared at start", alive_o, 0);
      if (restart_mid) begin
         while (log_n < 3) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      while (done_cnt == 0) @(negedge clk);
      chk(alive_o == exp_alive, "R7 alive result", alive_o, exp_alive);
      repeat (30) @(negedge clk);
      chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
      chk(log_n == 8, "R10 access count", log_n, 8);
      for (int i = 0; i < 7; i++)
         chk(log_w[i] && log_a[i] == EXP_A[i] && log_d[i] == EXP_D[i],
             i == 0 ? "R1 first write" : (i < 4 ? "R2 write order" : "R3 write order"),
             {log_w[i], log_a[i], log_d[i]}, {1'b1, EXP_A[i], EXP_D[i]});
      chk(!log_w[7] && log_a[7] == 5'h03, "R6 probe read", {log_w[7], log_a[7]}, 6'h03);
      chk(gap == WAIT_C, "R5 settle gap", gap, WAIT_C);
      chk(alive_o == exp_alive, "R8 alive held", alive_o, exp_alive);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!acc_req_o && !done_o && !alive_o, "R11 reset outputs",
          {acc_req_o, done_o, alive_o}, 0);
      rst_n = 1'b1;
      req_cnt = 0;
      repeat (10) @(negedge clk);
      chk(req_cnt == 0, "R11 no request without start", req_cnt, 0);
      for (int v = 0; v < NVEC; v++)
         run_seq(VEC[v][12:5], int'(VEC[v][4:1]), VEC[v][0], 1'b0);
      // directed: second start in the middle of the writes (R10), with R4 latency
      run_seq(8'h03, 2, 1'b1, 1'b1);
      run_seq(8'h00, 0, 1'b0, 1'b1);
      // directed: reset in the middle clears everything (R11)
      probe_val = 8'h03; lat = 1; log_n = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!acc_req_o && !done_o && !alive_o, "R11 mid-run reset",
          {acc_req_o, done_o, alive_o}, 0);
      finish_run();
   end
endmodule